// File: doc/BRIEF.md
# Early-Exit Tap Selector for a Processing-Element Chain

A linear chain of processing elements handles one query column per element, and a query only needs as many elements as its extension length. This block lets a job leave the chain at an intermediate exit tap instead of crossing every element. Several taps along the chain feed one multiplexer, and the multiplexer drives the single result stage.

When a job is accepted, the block picks the shortest tap that still covers the job's extension length. It latches that choice for the whole job and passes the selected tap's stream to the result stage. It also counts out the drain time: the tap position plus the reference length. When that time has run out, it pulses a done signal and becomes ready for the next job.

A job whose length is zero or longer than the chain is refused with an error pulse and never starts. While a job is draining, new start requests are ignored, whichever tap the new job would use.

Top module: `exit_tap_selector`

## Requirements
- R1: Tap k (k = 0 for the shortest) sits after element floor(CHAIN_LEN*(k+1)/NUM_TAPS); with the defaults these are 43, 87 and 131. An accepted job of length n selects the smallest k whose tap position is at least n, and `exit_sel_o` shows k from the cycle after acceptance.
- R2: A start with length 0 or length above CHAIN_LEN is refused. `reject_o` is high for exactly the one cycle after the request, `ready_o` stays high, and no `done_o` follows.
- R3: `ready_o` is high exactly when no job is in progress. A start request raised while `ready_o` is low is ignored.
- R4: `done_o` is a one-cycle pulse. It rises exactly P+R clock edges after the accepting edge, where P is the selected tap position and R is `ref_len_i`. `ready_o` is high again in the same cycle.
- R5: While a job is in progress, `out_data_o` equals slice [k*DW +: DW] of `tap_data_i` and `out_valid_o` equals bit k of `tap_valid_i`, where k is the latched tap. When no job is in progress, `out_valid_o` is 0.
- R6: The latched tap stays unchanged from acceptance until `done_o`, even if `ext_len_i` changes or a new start is raised meanwhile.
- R7: After reset, `ready_o` is 1, and `done_o`, `reject_o`, `out_valid_o` and `exit_sel_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to start a job (taken only when ready) |
| ext_len_i | input | LEN_W | Extension length of the job, in symbols |
| ref_len_i | input | REF_W | Reference length of the job, in rows |
| tap_data_i | input | NUM_TAPS*DW | Data from each exit tap; tap k occupies [k*DW +: DW] |
| tap_valid_i | input | NUM_TAPS | Valid from each exit tap; bit k belongs to tap k |
| ready_o | output | 1 | No job in progress; a start will be taken |
| reject_o | output | 1 | One-cycle pulse: the last start had an illegal length |
| exit_sel_o | output | IDX_W | Index of the latched exit tap |
| out_data_o | output | DW | Data forwarded to the result stage |
| out_valid_o | output | 1 | Valid forwarded to the result stage |
| done_o | output | 1 | One-cycle pulse: the job has fully drained |

## Verification
The bench builds the block with a 12-element chain, three taps (at 4, 8 and 12), 8-bit data and a 3-bit reference length. That makes the 4-bit length field cover every legal length and several illegal ones. The bench runs every pair of extension length 0 to 15 and reference length 0 to 7. It therefore reaches each tap boundary from both sides, the zero and overlong rejects, and every drain latency from 4 to 19 cycles. Some jobs raise a competing start in mid-drain to show that the first job keeps its tap and its timing.

// File: rtl/exit_tap_pkg.sv
package exit_tap_pkg;

    typedef enum logic {
        DRN_IDLE = 1'b0,
        DRN_BUSY = 1'b1
    } drain_state_e;

    // Element count after which exit tap k sits (k = 0 is the shortest)
    function automatic int tap_pos(input int chain_len, input int num_taps, input int k);
        return (chain_len * (k + 1)) / num_taps;
    endfunction

    function automatic int idx_width(input int num_taps);
        return (num_taps > 1) ? $clog2(num_taps) : 1;
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/exit_pick.sv
module exit_pick
    import exit_tap_pkg::*;
#(
    parameter int CHAIN_LEN = 131,
    parameter int NUM_TAPS  = 3,
    parameter int LEN_W     = $clog2(CHAIN_LEN + 1),
    parameter int IDX_W     = idx_width(NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LEN_W-1:0] len_i,
    output logic             len_ok_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [LEN_W-1:0] pos_o
);

    logic [LEN_W-1:0]    pos_tbl [NUM_TAPS];
    logic [NUM_TAPS-1:0] covers;

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        localparam logic [LEN_W-1:0] POS = LEN_W'(tap_pos(CHAIN_LEN, NUM_TAPS, k));
        assign pos_tbl[k] = POS;
        assign covers[k]  = (len_i <= POS);
    end

    assign len_ok_o = (len_i != '0) && (len_i <= LEN_W'(CHAIN_LEN));

    always_comb begin
        idx_o = IDX_W'(NUM_TAPS - 1);
        pos_o = pos_tbl[NUM_TAPS-1];
        for (int k = NUM_TAPS - 1; k >= 0; k--) begin
            if (covers[k]) begin
                idx_o = IDX_W'(k);
                pos_o = pos_tbl[k];
            end
        end
    end

    AST_PICK_COVERS: assert property (@(posedge clk) disable iff (rst)
        len_ok_o |-> (len_i <= pos_o)) else $error("picked tap too short"); // R1
    AST_PICK_SHORTEST: assert property (@(posedge clk) disable iff (rst)
        (len_ok_o && idx_o != '0) |-> (len_i > pos_tbl[idx_o - 1'b1])) else $error("shorter tap would do"); // R1

endmodule

// File: rtl/drain_ctrl.sv
module drain_ctrl
    import exit_tap_pkg::*;
#(
    parameter int LEN_W = 8,
    parameter int REF_W = 10,
    parameter int IDX_W = 2,
    localparam int CNT_W = max_int(LEN_W, REF_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             len_ok_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [LEN_W-1:0] pos_i,
    input  logic [REF_W-1:0] ref_len_i,
    output logic             busy_o,
    output logic [IDX_W-1:0] sel_o,
    output logic             done_o,
    output logic             reject_o
);

    drain_state_e     state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] sel_q;
    logic             done_q;
    logic             rej_q;
    logic             idle;
    logic             accept;
    logic             refuse;

    assign idle   = (state_q == DRN_IDLE);
    assign accept = start_i && idle && len_ok_i;
    assign refuse = start_i && idle && !len_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DRN_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
            done_q  <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            rej_q  <= refuse;
            unique case (state_q)
                DRN_IDLE: begin
                    if (accept) begin
                        state_q <= DRN_BUSY;
                        sel_q   <= idx_i;
                        cnt_q   <= CNT_W'(pos_i) + CNT_W'(ref_len_i);
                    end
                end
                DRN_BUSY: begin
                    if (cnt_q == CNT_W'(1)) begin
                        state_q <= DRN_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= DRN_IDLE;
            endcase
        end
    end

    assign busy_o   = !idle;
    assign sel_o    = sel_q;
    assign done_o   = done_q;
    assign reject_o = rej_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q) else $error("done longer than one cycle"); // R4
    AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(done_q) |-> $past(state_q == DRN_BUSY)) else $error("done without job"); // R4
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
        (state_q == DRN_BUSY && cnt_q != CNT_W'(1)) |=> (state_q == DRN_BUSY && $stable(sel_q))) else $error("tap changed mid-job"); // R6
    AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (rst)
        rej_q |-> idle) else $error("reject started a job"); // R2

endmodule

// File: rtl/tap_mux.sv
module tap_mux #(
    parameter int NUM_TAPS = 3,
    parameter int DW       = 16,
    parameter int IDX_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_TAPS*DW-1:0] tap_data_i,
    input  logic [NUM_TAPS-1:0]    tap_valid_i,
    input  logic [IDX_W-1:0]       sel_i,
    input  logic                   en_i,
    output logic [DW-1:0]          data_o,
    output logic                   valid_o
);

    logic [NUM_TAPS-1:0] hit;
    logic [DW-1:0]       term [NUM_TAPS];

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_leg
        assign hit[k]  = en_i && (sel_i == IDX_W'(k));
        assign term[k] = hit[k] ? tap_data_i[k*DW +: DW] : '0;
    end

    always_comb begin
        data_o = '0;
        for (int k = 0; k < NUM_TAPS; k++) begin
            data_o = data_o | term[k];
        end
    end

    assign valid_o = |(hit & tap_valid_i);

    AST_MUX_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit)) else $error("more than one tap open"); // R5
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !en_i |-> (!valid_o && data_o == '0)) else $error("output live while idle"); // R5

endmodule

// File: rtl/exit_tap_selector.sv
module exit_tap_selector
    import exit_tap_pkg::*;
#(
    parameter int CHAIN_LEN = 131,
    parameter int NUM_TAPS  = 3,
    parameter int DW        = 16,
    parameter int REF_W     = 10,
    localparam int LEN_W    = $clog2(CHAIN_LEN + 1),
    localparam int IDX_W    = idx_width(NUM_TAPS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic [LEN_W-1:0]       ext_len_i,
    input  logic [REF_W-1:0]       ref_len_i,
    input  logic [NUM_TAPS*DW-1:0] tap_data_i,
    input  logic [NUM_TAPS-1:0]    tap_valid_i,
    output logic                   ready_o,
    output logic                   reject_o,
    output logic [IDX_W-1:0]       exit_sel_o,
    output logic [DW-1:0]          out_data_o,
    output logic                   out_valid_o,
    output logic                   done_o
);

    logic             len_ok;
    logic [IDX_W-1:0] pick_idx;
    logic [LEN_W-1:0] pick_pos;
    logic             busy;
    logic [IDX_W-1:0] sel;

    exit_pick #(
        .CHAIN_LEN(CHAIN_LEN),
        .NUM_TAPS (NUM_TAPS),
        .LEN_W    (LEN_W),
        .IDX_W    (IDX_W)
    ) pick_i (
        .clk     (clk),
        .rst     (rst),
        .len_i   (ext_len_i),
        .len_ok_o(len_ok),
        .idx_o   (pick_idx),
        .pos_o   (pick_pos)
    );

    drain_ctrl #(
        .LEN_W(LEN_W),
        .REF_W(REF_W),
        .IDX_W(IDX_W)
    ) drain_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .len_ok_i (len_ok),
        .idx_i    (pick_idx),
        .pos_i    (pick_pos),
        .ref_len_i(ref_len_i),
        .busy_o   (busy),
        .sel_o    (sel),
        .done_o   (done_o),
        .reject_o (reject_o)
    );

    tap_mux #(
        .NUM_TAPS(NUM_TAPS),
        .DW      (DW),
        .IDX_W   (IDX_W)
    ) mux_i (
        .clk        (clk),
        .rst        (rst),
        .tap_data_i (tap_data_i),
        .tap_valid_i(tap_valid_i),
        .sel_i      (sel),
        .en_i       (busy),
        .data_o     (out_data_o),
        .valid_o    (out_valid_o)
    );

    assign ready_o    = !busy;
    assign exit_sel_o = sel;

    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !done_o) |=> (!ready_o || done_o)) else $error("job ended without done"); // R3
    AST_REJECT_KEEPS_READY: assert property (@(posedge clk) disable iff (rst)
        reject_o |-> ready_o) else $error("refused job went busy"); // R2

endmodule

// File: tb/exit_tap_selector_tb_top.sv
module exit_tap_selector_tb_top;

    localparam int CL    = 12;
    localparam int NT    = 3;
    localparam int DW    = 8;
    localparam int REF_W = 3;
    localparam int LEN_W = $clog2(CL + 1);
    localparam int IDX_W = 2;

    logic                 clk = 1'b0;
    logic                 rst = 1'b1;
    logic                 start_i = 1'b0;
    logic [LEN_W-1:0]     ext_len_i = '0;
    logic [REF_W-1:0]     ref_len_i = '0;
    logic [NT*DW-1:0]     tap_data_i = '0;
    logic [NT-1:0]        tap_valid_i = '0;
    logic                 ready_o;
    logic                 reject_o;
    logic [IDX_W-1:0]     exit_sel_o;
    logic [DW-1:0]        out_data_o;
    logic                 out_valid_o;
    logic                 done_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    exit_tap_selector #(
        .CHAIN_LEN(CL),
        .NUM_TAPS (NT),
        .DW       (DW),
        .REF_W    (REF_W)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .ext_len_i  (ext_len_i),
        .ref_len_i  (ref_len_i),
        .tap_data_i (tap_data_i),
        .tap_valid_i(tap_valid_i),
        .ready_o    (ready_o),
        .reject_o   (reject_o),
        .exit_sel_o (exit_sel_o),
        .out_data_o (out_data_o),
        .out_valid_o(out_valid_o),
        .done_o     (done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_job(input int len, input int rl, input bit intrude);
        int e_idx;
        int e_lat;
        int n;
        bit legal;
        legal = (len >= 1) && (len <= CL);
        e_idx = legal ? ((len * NT + CL - 1) / CL - 1) : 0;
        e_lat = (CL * (e_idx + 1)) / NT + rl;
        for (int k = 0; k < NT; k++) tap_data_i[k*DW +: DW] = DW'(8'h31 * (k + 1) + len);
        tap_valid_i = NT'(len ^ rl);
        @(negedge clk);
        check(ready_o == 1'b1, "R3 ready before start", int'(ready_o), 1);
        start_i   = 1'b1;
        ext_len_i = LEN_W'(len);
        ref_len_i = REF_W'(rl);
        @(negedge clk);
        start_i = 1'b0;
        if (!legal) begin
            check(reject_o == 1'b1, "R2 reject pulse", int'(reject_o), 1);
            check(ready_o == 1'b1, "R2 ready kept", int'(ready_o), 1);
            @(negedge clk);
            check(reject_o == 1'b0, "R2 reject one cycle", int'(reject_o), 0);
            check(done_o == 1'b0, "R2 no done", int'(done_o), 0);
            return;
        end
        check(reject_o == 1'b0, "R2 no reject", int'(reject_o), 0);
        check(ready_o == 1'b0, "R3 busy after accept", int'(ready_o), 0);
        check(int'(exit_sel_o) == e_idx, "R1 tap choice", int'(exit_sel_o), e_idx);
        ext_len_i = LEN_W'(CL - len + 1);
        n = 0;
        while (!done_o && n <= e_lat + 2) begin
            check(int'(out_data_o) == int'(tap_data_i[e_idx*DW +: DW]), "R5 data", int'(out_data_o),
                  int'(tap_data_i[e_idx*DW +: DW]));
            check(out_valid_o == tap_valid_i[e_idx], "R5 valid", int'(out_valid_o), int'(tap_valid_i[e_idx]));
            check(int'(exit_sel_o) == e_idx, "R6 tap held", int'(exit_sel_o), e_idx);
            start_i   = intrude && (n == 1);
            ext_len_i = LEN_W'(1);
            @(negedge clk);
            n++;
        end
        start_i = 1'b0;
        check(n == e_lat, "R4 drain latency", n, e_lat);
        check(ready_o == 1'b1, "R4 ready with done", int'(ready_o), 1);
        check(out_valid_o == 1'b0, "R5 idle valid", int'(out_valid_o), 0);
        @(negedge clk);
        check(done_o == 1'b0, "R4 done one cycle", int'(done_o), 0);
        check(ready_o == 1'b1, "R3 intruding start ignored", int'(ready_o), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R7 reset state
        check(ready_o == 1'b1, "R7 ready", int'(ready_o), 1);
        check(done_o == 1'b0, "R7 done", int'(done_o), 0);
        check(reject_o == 1'b0, "R7 reject", int'(reject_o), 0);
        check(out_valid_o == 1'b0, "R7 valid", int'(out_valid_o), 0);
        check(exit_sel_o == '0, "R7 sel", int'(exit_sel_o), 0);
        for (int l = 0; l < (1 << LEN_W); l++) begin
            for (int r = 0; r < (1 << REF_W); r++) begin
                run_job(l, r, ((l + r) % 3) == 0);
            end
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule